// File: doc/BRIEF.md
# Paired Double-Precision Sum and Difference Unit

This block accepts two IEEE double-precision operands and produces both `x + y` and `x - y` in one operation. The exponent comparison, operand ordering and mantissa alignment are done once per operand pair. The aligned pair then goes to one magnitude adder and one magnitude subtractor. When the operand signs match, the adder produces the sum and the subtractor produces the difference. When the signs differ, the roles swap. Each path normalizes and rounds to nearest-even on its own, using guard, round and sticky bits.

The adder path never needs more than a one-bit right shift to renormalize. The subtractor path may need a left shift across the whole significand and may cancel to zero. The unit is a two-stage pipeline. Stage one unpacks, compares and aligns the operands. Stage two adds, subtracts, normalizes and rounds, and its result register drives the output.

Both results leave together under one `out_valid`, so the two paths stay aligned however far either one had to shift. Input and output are valid/ready streams:
- A pair is taken on a clock edge where `in_valid` and `in_ready` are both high.
- A result is consumed on an edge where `out_valid` and `out_ready` are both high.
- While `out_valid` is high and `out_ready` is low, the outputs stay frozen.
- `in_ready` falls only when both stages hold data and the consumer is stalling.

Top module: `fpdas_top`

## Requirements
- R1: A pair accepted on clock edge k appears with `out_valid` high after edge k+1 and not before. One `out_valid` covers both results.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sum`, `out_diff` and both flag words hold steady. With both stages full and the output stalled, `in_ready` is low. Results leave in arrival order.
- R3: For normal operands whose exact results are normal, `out_sum` and `out_diff` equal the correctly rounded (nearest, ties to even) double of x+y and x−y. This includes exponent gaps larger than the significand width and operand pairs where |y| > |x|.
- R4: A subtraction of equal magnitudes gives +0 (64'h0) with all flags clear.
- R5: A zero produced by adding two zero magnitudes keeps their common sign: (−0)+(−0) = −0 and (−0)−(+0) = −0, while (+0)+(−0) and (−0)−(−0) give +0.
- R6: An input whose exponent field is 0 is taken as a zero of its own sign, whatever its fraction bits.
- R7: If the rounded result's biased exponent reaches 2047, the result is infinity with the result's sign and flag bit 1 (overflow) set.
- R8: If a subtraction's normalized biased exponent before rounding is 0 or less, the result is a zero with the result's sign and flag bit 0 (underflow) set.
- R9: If either input has an all-ones exponent field (infinity or NaN), both outputs are 64'h7FF8_0000_0000_0000 and both flag words are 3'b100 (bit 2 = invalid).
- R10: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand pair valid |
| in_ready | output | 1 | Unit can take a pair this cycle |
| in_x | input | 64 | First operand, IEEE double |
| in_y | input | 64 | Second operand, IEEE double |
| out_valid | output | 1 | Both results valid |
| out_ready | input | 1 | Consumer takes the results this cycle |
| out_sum | output | 64 | x + y |
| out_diff | output | 64 | x − y |
| sum_flags | output | 3 | {invalid, overflow, underflow} for the sum |
| diff_flags | output | 3 | {invalid, overflow, underflow} for the difference |

## Verification
The main function is driven with several kinds of operand pair, each checked against real-number arithmetic worked out in the bench:
- Like-signed pairs and unlike-signed pairs, which show whether the adder and subtractor outputs are routed to the right result.
- Pairs where the second magnitude is larger, which exercise the operand swap and the sign chosen on the subtract path.
- A near-equal pair that cancels most of the significand, which exercises the deep left shift.
- A pair whose exponent gap exceeds the significand width, which leaves only sticky information and tests rounding.

Signed-zero pairs, subnormal inputs, the largest finite values and tiny normals show the flush, saturation and flag behaviour. A stalled consumer with three pairs in flight shows the hold, ordering and back-pressure rules.

// File: rtl/fpdas_pkg.sv
package fpdas_pkg;
  localparam int EW   = 11;             // exponent field width
  localparam int FW   = 52;             // fraction field width
  localparam int DW   = 1 + EW + FW;    // word width
  localparam int MW   = FW + 1;         // significand with hidden bit
  localparam int XW   = MW + 3;         // significand plus guard, round, sticky
  localparam int LZW  = $clog2(XW + 1);
  localparam int SW   = EW + 2;         // signed working exponent width
  localparam logic [EW-1:0] EMAX = {EW{1'b1}};
  localparam logic [DW-1:0] QNAN = {1'b0, EMAX, 1'b1, {(FW-1){1'b0}}};

  typedef struct packed {
    logic          spec;   // an operand had an all-ones exponent
    logic          sx;     // sign of x
    logic          same;   // operand signs equal
    logic          swp;    // |y| > |x|
    logic [EW-1:0] eb;     // exponent of the larger magnitude
    logic [XW-1:0] big;    // larger significand, extended
    logic [XW-1:0] sml;    // aligned smaller significand with sticky
  } stage_t;
endpackage

// File: rtl/fpdas_align.sv
module fpdas_align
  import fpdas_pkg::*;
(
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  output stage_t        o
);
  localparam int WW = MW + XW;
  localparam int DCW = EW;

  logic [EW-1:0]  ex, ey, es;
  logic [MW-1:0]  mx, my, mb, ms;
  logic [DCW-1:0] d;
  logic [LZW-1:0] dcap;
  logic [WW-1:0]  sh;

  always_comb begin
    // exponent field zero: treated as zero (subnormals flushed)
    ex = x[DW-2:FW];
    ey = y[DW-2:FW];
    mx = (ex == '0) ? '0 : {1'b1, x[FW-1:0]};
    my = (ey == '0) ? '0 : {1'b1, y[FW-1:0]};
    o.spec = (ex == EMAX) || (ey == EMAX);
    o.sx   = x[DW-1];
    o.same = (x[DW-1] == y[DW-1]);
    o.swp  = {ey, my} > {ex, mx};
    o.eb   = o.swp ? ey : ex;
    es     = o.swp ? ex : ey;
    mb     = o.swp ? my : mx;
    ms     = o.swp ? mx : my;
    // single alignment shared by both result paths
    d      = o.eb - es;
    dcap   = (d > DCW'(XW)) ? LZW'(XW) : d[LZW-1:0];
    sh     = {ms, {XW{1'b0}}} >> dcap;
    o.big  = {mb, 3'b000};
    o.sml  = {sh[WW-1:MW+1], |sh[MW:0]};
  end
endmodule

// File: rtl/fpdas_path.sv
module fpdas_path
  import fpdas_pkg::*;
#(
  parameter bit SUB = 1'b0
)(
  input  logic [EW-1:0] eb,
  input  logic [XW-1:0] big,
  input  logic [XW-1:0] sml,
  input  logic          sign,
  output logic [DW-1:0] res,
  output logic          ovf,
  output logic          unf
);
  logic [XW-1:0]        n;      // normalized, hidden bit at top
  logic signed [SW-1:0] e;      // biased exponent before rounding
  logic                 zero;
  logic                 zsign;

  generate
    if (SUB) begin : g_sub
      logic [XW-1:0]  df;
      logic [LZW-1:0] lz;
      logic           found;
      always_comb begin
        df    = big - sml;
        lz    = '0;
        found = 1'b0;
        for (int i = XW - 1; i >= 0; i--) begin
          if (!found) begin
            if (df[i]) found = 1'b1;
            else       lz    = lz + 1'b1;
          end
        end
        n     = df << lz;
        e     = SW'(eb) - SW'(lz);
        zero  = (df == '0);
        zsign = 1'b0;
      end
    end else begin : g_add
      logic [XW:0] s;
      always_comb begin
        s     = {1'b0, big} + {1'b0, sml};
        n     = s[XW] ? {s[XW:2], s[1] | s[0]} : s[XW-1:0];
        e     = SW'(eb) + SW'(s[XW]);
        zero  = (big == '0);
        zsign = sign;
      end
    end
  endgenerate

  logic                 inc;
  logic [MW:0]          mr;
  logic signed [SW-1:0] ef;

  always_comb begin
    inc = n[2] & (n[1] | n[0] | n[3]);
    mr  = {1'b0, n[XW-1:3]} + MW'(inc);
    ef  = e + SW'(mr[MW]);
    ovf = 1'b0;
    unf = 1'b0;
    if (zero) begin
      res = {zsign, {(DW-1){1'b0}}};
    end else if (e <= 0) begin
      res = {sign, {(DW-1){1'b0}}};
      unf = 1'b1;
    end else if (ef >= SW'(EMAX)) begin
      res = {sign, EMAX, {FW{1'b0}}};
      ovf = 1'b1;
    end else begin
      res = {sign, ef[EW-1:0], mr[FW-1:0]};
    end
  end
endmodule

// File: rtl/fpdas_top.sv
module fpdas_top
  import fpdas_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [63:0]   in_x,
  input  logic [63:0]   in_y,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [63:0]   out_sum,
  output logic [63:0]   out_diff,
  output logic [2:0]    sum_flags,
  output logic [2:0]    diff_flags
);
  stage_t        a_c, s1_q;
  logic          v1;
  logic          adv1, adv2;
  logic [DW-1:0] add_res, sub_res, sum_c, diff_c;
  logic          add_ovf, add_unf, sub_ovf, sub_unf;
  logic [2:0]    sf_c, df_c, f_add, f_sub;

  assign adv2     = !out_valid || out_ready;
  assign adv1     = !v1 || adv2;
  assign in_ready = adv1;

  fpdas_align u_align (.x(in_x), .y(in_y), .o(a_c));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1   <= 1'b0;
      s1_q <= '0;
    end else if (adv1) begin
      v1 <= in_valid;
      if (in_valid) s1_q <= a_c;
    end
  end

  fpdas_path #(.SUB(1'b0)) u_add (
    .eb(s1_q.eb), .big(s1_q.big), .sml(s1_q.sml), .sign(s1_q.sx),
    .res(add_res), .ovf(add_ovf), .unf(add_unf));

  fpdas_path #(.SUB(1'b1)) u_sub (
    .eb(s1_q.eb), .big(s1_q.big), .sml(s1_q.sml), .sign(s1_q.sx ^ s1_q.swp),
    .res(sub_res), .ovf(sub_ovf), .unf(sub_unf));

  always_comb begin
    f_add = {1'b0, add_ovf, add_unf};
    f_sub = {1'b0, sub_ovf, sub_unf};
    if (s1_q.spec) begin
      sum_c  = QNAN;
      diff_c = QNAN;
      sf_c   = 3'b100;
      df_c   = 3'b100;
    end else begin
      sum_c  = s1_q.same ? add_res : sub_res;
      diff_c = s1_q.same ? sub_res : add_res;
      sf_c   = s1_q.same ? f_add : f_sub;
      df_c   = s1_q.same ? f_sub : f_add;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sum    <= '0;
      out_diff   <= '0;
      sum_flags  <= '0;
      diff_flags <= '0;
    end else if (adv2) begin
      out_valid <= v1;
      if (v1) begin
        out_sum    <= sum_c;
        out_diff   <= diff_c;
        sum_flags  <= sf_c;
        diff_flags <= df_c;
      end
    end
  end

  // R1: output only follows a filled first stage
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(v1));
  // R2: stalled output holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sum) && $stable(out_diff)
      && $stable(sum_flags) && $stable(diff_flags));
  // R3: alignment never leaves the smaller operand above the larger
  p_align_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |-> s1_q.big >= s1_q.sml);
  // R7: overflow flag implies infinity
  p_ovf_inf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && sum_flags[1] |-> out_sum[62:0] == {EMAX, {FW{1'b0}}});
  // R8: underflow flag implies zero magnitude
  p_unf_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && diff_flags[0] |-> out_diff[62:0] == '0);
  // R9: invalid flags come in pairs with a quiet NaN
  p_inv_nan_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && sum_flags[2] |-> diff_flags[2] && out_sum == QNAN && out_diff == QNAN);
endmodule

// File: tb/fpdas_top_tb.sv
module fpdas_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_x = '0, in_y = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_sum, out_diff;
  logic [2:0]  sum_flags, diff_flags;
  int errors = 0;
  int checks = 0;
  int cyc = 0;

  localparam logic [63:0] QN   = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] MAXD = 64'h7FEF_FFFF_FFFF_FFFF;
  localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;

  fpdas_top u_dut (.*);

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d cycles exp=<20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [63:0] x, input logic [63:0] y);
    logic ok;
    in_x = x; in_y = y; in_valid = 1'b1;
    forever begin
      ok = in_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop_chk(input string tag, input logic [63:0] es, input logic [63:0] ed,
                         input logic [2:0] fs, input logic [2:0] fd);
    while (!out_valid) @(negedge clk);
    chk({tag, " sum"}, out_sum, es);
    chk({tag, " diff"}, out_diff, ed);
    chk({tag, " sflags"}, 64'(sum_flags), 64'(fs));
    chk({tag, " dflags"}, 64'(diff_flags), 64'(fd));
    @(negedge clk);
  endtask

  task automatic run_real(input string tag, input real a, input real b);
    push($realtobits(a), $realtobits(b));
    pop_chk(tag, $realtobits(a + b), $realtobits(a - b), 3'b000, 3'b000);
  endtask

  task automatic t_reset;
    chk("R10 out_valid", 64'(out_valid), 64'd0);
    chk("R10 in_ready", 64'(in_ready), 64'd1);
  endtask

  task automatic t_latency;
    push($realtobits(1.5), $realtobits(2.25));
    chk("R1 not early", 64'(out_valid), 64'd0);
    @(negedge clk);
    chk("R1 on time", 64'(out_valid), 64'd1);
    pop_chk("R1 values", $realtobits(3.75), $realtobits(-0.75), 3'b000, 3'b000);
  endtask

  task automatic t_arith;
    run_real("R3 like", 3.0, 1.0);
    run_real("R3 unlike", -7.25, 0.1);
    run_real("R3 tenths", 0.1, 0.2);
    run_real("R3 swap", 2.0, -5.5);
    run_real("R3 big", 1.0e300, -3.0e299);
    run_real("R3 cancel-deep", 1.0, 0.9999999999999999);
    run_real("R3 gap", 1.0, 8.673617379884035e-19);
    run_real("R3 gap-neg", -3.0, 1.2e-40);
  endtask

  task automatic t_cancel;
    push($realtobits(3.5), $realtobits(3.5));
    pop_chk("R4 pos", $realtobits(7.0), 64'h0, 3'b000, 3'b000);
    push($realtobits(-3.5), $realtobits(-3.5));
    pop_chk("R4 neg", $realtobits(-7.0), 64'h0, 3'b000, 3'b000);
  endtask

  task automatic t_zero;
    push(NZ, NZ);
    pop_chk("R5 negneg", NZ, 64'h0, 3'b000, 3'b000);
    push(NZ, 64'h0);
    pop_chk("R5 negpos", 64'h0, NZ, 3'b000, 3'b000);
  endtask

  task automatic t_subnorm;
    push(64'h0000_0000_0000_0001, $realtobits(1.0));
    pop_chk("R6 sub-in", $realtobits(1.0), $realtobits(-1.0), 3'b000, 3'b000);
  endtask

  task automatic t_ovf;
    push(MAXD, MAXD);
    pop_chk("R7 pos", PINF, 64'h0, 3'b010, 3'b000);
    push({1'b1, MAXD[62:0]}, MAXD);
    pop_chk("R7 neg", 64'h0, NINF, 3'b000, 3'b010);
  endtask

  task automatic t_unf;
    push(64'h0018_0000_0000_0000, 64'h0010_0000_0000_0000);
    pop_chk("R8 flush", 64'h0024_0000_0000_0000, 64'h0, 3'b000, 3'b001);
  endtask

  task automatic t_special;
    push(PINF, $realtobits(1.0));
    pop_chk("R9 inf", QN, QN, 3'b100, 3'b100);
    push($realtobits(2.0), 64'hFFF8_0000_0000_0001);
    pop_chk("R9 nan", QN, QN, 3'b100, 3'b100);
  endtask

  task automatic t_backpressure;
    logic [63:0] hs;
    out_ready = 1'b0;
    push($realtobits(1.0), $realtobits(2.0));
    push($realtobits(4.0), $realtobits(8.0));
    in_x = $realtobits(16.0); in_y = $realtobits(32.0); in_valid = 1'b1;
    @(negedge clk);
    chk("R2 ready low", 64'(in_ready), 64'd0);
    hs = out_sum;
    repeat (3) @(negedge clk);
    chk("R2 hold valid", 64'(out_valid), 64'd1);
    chk("R2 hold sum", out_sum, hs);
    chk("R2 first sum", out_sum, $realtobits(3.0));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    pop_chk("R2 order B", $realtobits(12.0), $realtobits(-4.0), 3'b000, 3'b000);
    pop_chk("R2 order C", $realtobits(48.0), $realtobits(-16.0), 3'b000, 3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_latency;
    t_arith;
    t_cancel;
    t_zero;
    t_subnorm;
    t_ovf;
    t_unf;
    t_special;
    t_backpressure;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule